// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Mirror

This block holds the interrupt pending and block bits of a two-channel disk controller inside a small byte-addressed configuration space, and drives one level-sensitive interrupt line. Each channel supplies an interrupt level. When that level changes, the matching pending bit in a shared mode byte follows it. The same pending state is also kept in a per-channel legacy status byte. Software can therefore read or clear a pending interrupt through either location, and the two copies always agree.

The configuration port works on 32-bit words selected by a word index, with four byte enables. The byte at offset `4*index + lane` sits on lane `lane`. All the bytes this block owns are read-only, except for the pending bits, which are write-one-to-clear. A separate narrow port loads the two block bits, which mask a channel's pending bit before it reaches the interrupt output. A strap input reports whether the second channel is enabled.

Top module: `intr_status_mirror`

## Requirements
- R1: While reset is asserted, and at the first check after it is released, both pending bits and both block bits are 0 and `irq_out` is 0.
- R2: A low-to-high change on `ch_irq_lvl[c]` sets channel c's pending bit. After the clock edge that samples the change, the bit reads 1 in mode byte 0x71 (bit 2 for channel 0, bit 3 for channel 1) and in its legacy byte (bit 2 of byte 0x50 for channel 0, bit 4 of byte 0x57 for channel 1).
- R3: A high-to-low change on `ch_irq_lvl[c]` clears channel c's pending bit in both locations after the sampling edge.
- R4: A configuration write with the legacy byte's lane enabled and a 1 in that channel's legacy bit clears the pending bit in both locations. A 0 in that bit leaves the pending bit as it was.
- R5: A configuration write with lane 1 of word 0x1C (byte 0x71) enabled clears channel c's pending bit in both locations wherever bit 2+c of that byte is 1.
- R6: A configuration write changes no bit other than the pending bits. This covers the block bits at bits 4 and 5 of byte 0x71, and any byte whose lane enable is low.
- R7: `irq_out` equals (pending0 and not block0) or (pending1 and not block1), and follows register changes without an extra cycle.
- R8: A cycle with `blk_wr` high loads `blk_wdata` into the block bits. They read back at bit 4 (channel 0) and bit 5 (channel 1) of byte 0x71.
- R9: When a rising level and a write-one-to-clear of the same pending bit meet in one cycle, the bit ends up set. This holds whichever location is cleared.
- R10: Byte 0x51 always has bit 2 set. Its bit 3 equals `sec_en_strap`, and all its other bits are 0.
- R11: Byte 0x09 reads 0x8F and byte 0x3D reads 0x01.
- R12: After a pending bit is cleared while its level stays high, the bit stays 0 until the level falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| ch_irq_lvl | input | 2 | Interrupt level of each channel |
| sec_en_strap | input | 1 | Second-channel enable strap, shown in byte 0x51 bit 3 |
| blk_wr | input | 1 | Load strobe for the block bits |
| blk_wdata | input | 2 | New block bits, bit c for channel c |
| cfg_word | input | 6 | Configuration word index (byte offset / 4) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte-lane enables of a configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for the indexed word |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The hardest case to reach from the ports is a level edge that lands in the same cycle as a write-one-to-clear of the same bit. First the level has to be dropped so that it can rise again. Then the write and the new edge have to be lined up on one clock. The bench reaches this case directly, through both the legacy location and the mode location. It also runs a random phase in which level flips, writes to the three status words with random lanes and data, and block loads overlap freely. A companion case clears a bit while the level stays high and confirms that nothing re-sets it.

// File: rtl/ism_pkg.sv
`timescale 1ns/1ps
package ism_pkg;
  localparam int NUM_CH        = 2;

  // Byte offsets inside the configuration space
  localparam int OFF_PROGIF    = 'h09;
  localparam int OFF_INTPIN    = 'h3D;
  localparam int OFF_LEG0      = 'h50;
  localparam int OFF_CTRL      = 'h51;
  localparam int OFF_LEG1      = 'h57;
  localparam int OFF_MODE      = 'h71;

  // Bit positions within those bytes
  localparam int LEG0_BIT      = 2;
  localparam int LEG1_BIT      = 4;
  localparam int MODE_PEND_LSB = 2;
  localparam int MODE_BLK_LSB  = 4;
  localparam int CTRL_EN0_BIT  = 2;
  localparam int CTRL_EN1_BIT  = 3;

  localparam logic [7:0] PROGIF_VAL = 8'h8F;
  localparam logic [7:0] INTPIN_VAL = 8'h01;

  function automatic int leg_off(input int ch);
    return (ch == 0) ? OFF_LEG0 : OFF_LEG1;
  endfunction

  function automatic int leg_bit(input int ch);
    return (ch == 0) ? LEG0_BIT : LEG1_BIT;
  endfunction
endpackage

// File: rtl/ism_rst_sync.sv
`timescale 1ns/1ps
module ism_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ism_cfg_decode.sv
`timescale 1ns/1ps
module ism_cfg_decode #(
  parameter int CW  = 6,
  parameter int DW  = 32,
  parameter int NCH = 2
) (
  input  logic [CW-1:0]   cfg_word,
  input  logic            cfg_wr,
  input  logic [DW/8-1:0] cfg_be,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [NCH-1:0]  touch_leg,
  output logic [NCH-1:0]  clr_leg,
  output logic            touch_mode,
  output logic [NCH-1:0]  clr_mode
);
  import ism_pkg::*;
  localparam int LANES     = DW / 8;
  localparam int MODE_LANE = OFF_MODE % LANES;
  localparam logic [CW-1:0] MODE_WORD = CW'(OFF_MODE / LANES);

  assign touch_mode = cfg_wr && (cfg_word == MODE_WORD) && cfg_be[MODE_LANE];

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    localparam int LOFF  = leg_off(c);
    localparam int LLANE = LOFF % LANES;
    localparam logic [CW-1:0] LWORD = CW'(LOFF / LANES);
    assign touch_leg[c] = cfg_wr && (cfg_word == LWORD) && cfg_be[LLANE];
    assign clr_leg[c]   = touch_leg[c] && cfg_wdata[LLANE*8 + leg_bit(c)];
    assign clr_mode[c]  = touch_mode && cfg_wdata[MODE_LANE*8 + MODE_PEND_LSB + c];
  end
endmodule

// File: rtl/ism_chan.sv
`timescale 1ns/1ps
module ism_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic touch_leg,
  input  logic clr_leg,
  input  logic touch_mode,
  input  logic clr_mode,
  output logic lvl_seen,
  output logic pend_mode,
  output logic pend_leg
);
  logic lvl_q, mode_q, leg_q;
  logic mode_d, leg_d, upd;
  logic rise, fall, mode_w, leg_w;

  always_comb begin
    rise   = lvl & ~lvl_q;
    fall   = ~lvl & lvl_q;
    // write-one-to-clear on each location
    mode_w = mode_q & ~clr_mode;
    leg_w  = leg_q & ~clr_leg;
    // mirror once after the write, from the location that was touched
    mode_d = touch_leg  ? leg_w  : mode_w;
    leg_d  = touch_mode ? mode_w : leg_w;
    // a level edge in the same cycle takes priority
    if (rise) begin
      mode_d = 1'b1;
      leg_d  = 1'b1;
    end else if (fall) begin
      mode_d = 1'b0;
      leg_d  = 1'b0;
    end
    upd = rise | fall | touch_leg | touch_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      mode_q <= 1'b0;
      leg_q  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (upd) begin
        mode_q <= mode_d;
        leg_q  <= leg_d;
      end
    end
  end

  assign lvl_seen  = lvl_q;
  assign pend_mode = mode_q;
  assign pend_leg  = leg_q;
endmodule

// File: rtl/ism_cfg_rdmux.sv
`timescale 1ns/1ps
module ism_cfg_rdmux #(
  parameter int CW  = 6,
  parameter int DW  = 32,
  parameter int NCH = 2
) (
  input  logic [CW-1:0]  cfg_word,
  input  logic [NCH-1:0] pend_mode,
  input  logic [NCH-1:0] pend_leg,
  input  logic [NCH-1:0] blk,
  input  logic           strap,
  output logic [DW-1:0]  cfg_rdata
);
  import ism_pkg::*;
  localparam int LANES = DW / 8;

  function automatic logic [7:0] byte_at(input int off, input logic [NCH-1:0] pm,
                                         input logic [NCH-1:0] pl, input logic [NCH-1:0] bk,
                                         input logic st);
    logic [7:0] v;
    v = '0;
    if (off == OFF_PROGIF) v = PROGIF_VAL;
    else if (off == OFF_INTPIN) v = INTPIN_VAL;
    else if (off == OFF_CTRL) begin
      v[CTRL_EN0_BIT] = 1'b1;
      v[CTRL_EN1_BIT] = st;
    end else if (off == OFF_MODE) begin
      for (int c = 0; c < NCH; c++) begin
        v[MODE_PEND_LSB + c] = pm[c];
        v[MODE_BLK_LSB + c]  = bk[c];
      end
    end else begin
      for (int c = 0; c < NCH; c++)
        if (off == leg_off(c)) v[leg_bit(c)] = pl[c];
    end
    return v;
  endfunction

  always_comb begin
    cfg_rdata = '0;
    for (int l = 0; l < LANES; l++)
      cfg_rdata[l*8 +: 8] = byte_at(int'(cfg_word) * LANES + l, pend_mode, pend_leg, blk, strap);
  end
endmodule

// File: rtl/intr_status_mirror.sv
`timescale 1ns/1ps
module intr_status_mirror #(
  parameter int CW         = 6,
  parameter int DW         = 32,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ch_irq_lvl,
  input  logic          sec_en_strap,
  input  logic          blk_wr,
  input  logic [1:0]    blk_wdata,
  input  logic [CW-1:0] cfg_word,
  input  logic          cfg_wr,
  input  logic [DW/8-1:0] cfg_be,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq_out
);
  localparam int NCH = ism_pkg::NUM_CH;

  logic           rst_sync_n;
  logic [NCH-1:0] touch_leg, clr_leg, clr_mode;
  logic           touch_mode;
  logic [NCH-1:0] lvl_q, pend_mode, pend_leg;
  logic [NCH-1:0] blk_q, blk_d;

  ism_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  ism_cfg_decode #(.CW(CW), .DW(DW), .NCH(NCH)) u_dec (
    .cfg_word(cfg_word), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .touch_leg(touch_leg), .clr_leg(clr_leg), .touch_mode(touch_mode), .clr_mode(clr_mode)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ism_chan u_chan (
      .clk(clk), .rst_n(rst_sync_n), .lvl(ch_irq_lvl[c]),
      .touch_leg(touch_leg[c]), .clr_leg(clr_leg[c]),
      .touch_mode(touch_mode), .clr_mode(clr_mode[c]),
      .lvl_seen(lvl_q[c]), .pend_mode(pend_mode[c]), .pend_leg(pend_leg[c])
    );
  end

  // block bits: loaded only from the dedicated port
  always_comb blk_d = blk_wr ? blk_wdata : blk_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) blk_q <= '0;
    else             blk_q <= blk_d;
  end

  assign irq_out = |(pend_mode & ~blk_q);

  ism_cfg_rdmux #(.CW(CW), .DW(DW), .NCH(NCH)) u_rd (
    .cfg_word(cfg_word), .pend_mode(pend_mode), .pend_leg(pend_leg),
    .blk(blk_q), .strap(sec_en_strap), .cfg_rdata(cfg_rdata)
  );
endmodule

// File: rtl/ism_chk.sv
`timescale 1ns/1ps
module ism_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [1:0]    ch_irq_lvl,
  input logic [1:0]    lvl_q,
  input logic [1:0]    pend_mode,
  input logic [1:0]    pend_leg,
  input logic [1:0]    blk_q,
  input logic          blk_wr,
  input logic [1:0]    blk_wdata,
  input logic [CW-1:0] cfg_word,
  input logic [7:0]    rd_lane1,
  input logic          sec_en_strap,
  input logic          irq_out
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    // R2
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ch_irq_lvl[c] && !lvl_q[c]) |=> (pend_mode[c] && pend_leg[c]));
    // R3
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!ch_irq_lvl[c] && lvl_q[c]) |=> (!pend_mode[c] && !pend_leg[c]));
    // R12
    held_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ch_irq_lvl[c] && lvl_q[c] && !pend_mode[c]) |=> !pend_mode[c]);
  end

  // R4
  alias_coherent_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_mode == pend_leg);

  // R8
  blk_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk_wr |=> (blk_q == $past(blk_wdata)));

  // R6
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !blk_wr |=> $stable(blk_q));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pend_mode == 2'b00) || (blk_q == 2'b11)) |-> !irq_out);

  // R10
  ctrl_byte_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_word == CW'(6'h14)) |-> (rd_lane1 == {4'b0, sec_en_strap, 1'b1, 2'b0}));
endmodule

bind intr_status_mirror ism_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .ch_irq_lvl(ch_irq_lvl), .lvl_q(lvl_q),
  .pend_mode(pend_mode), .pend_leg(pend_leg), .blk_q(blk_q), .blk_wr(blk_wr),
  .blk_wdata(blk_wdata), .cfg_word(cfg_word), .rd_lane1(cfg_rdata[15:8]),
  .sec_en_strap(sec_en_strap), .irq_out(irq_out)
);

// File: tb/intr_status_mirror_test.sv
`timescale 1ns/1ps
module intr_status_mirror_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  lvl;
  logic        strap;
  logic        blk_wr;
  logic [1:0]  blk_wdata;
  logic [5:0]  cfg_word;
  logic        cfg_wr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [1:0] m_p, m_b;

  always #2 clk = ~clk;

  intr_status_mirror uut (
    .clk(clk), .rst_n(rst_n), .ch_irq_lvl(lvl), .sec_en_strap(strap),
    .blk_wr(blk_wr), .blk_wdata(blk_wdata), .cfg_word(cfg_word), .cfg_wr(cfg_wr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_out(irq)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [5:0] w);
    case (w)
      6'h02: return {16'h0, 8'h8F, 8'h00};
      6'h0F: return {16'h0, 8'h01, 8'h00};
      6'h14: return {16'h0, 4'b0, strap, 1'b1, 2'b0, 5'b0, m_p[0], 2'b0};
      6'h15: return {3'b0, m_p[1], 4'b0, 24'h0};
      6'h1C: return {16'h0, 2'b0, m_b, m_p, 2'b0, 8'h00};
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(input string tag, input logic [5:0] w);
    cfg_word = w;
    #0.2;
    cmp(tag, cfg_rdata, exp_word(w));
  endtask

  task automatic chk(input string tag);
    cmp(tag, {31'b0, irq}, {31'b0, |(m_p & ~m_b)});
    rd(tag, 6'h14);
    rd(tag, 6'h15);
    rd(tag, 6'h1C);
  endtask

  // one clock with the given stimulus; model follows the requirements
  task automatic cyc(input logic [1:0] l, input logic wr, input logic [5:0] w,
                     input logic [3:0] be, input logic [31:0] d,
                     input logic bw, input logic [1:0] bd);
    logic [1:0] clr, np;
    clr[0] = wr && ((w == 6'h14 && be[0] && d[2]) || (w == 6'h1C && be[1] && d[10]));
    clr[1] = wr && ((w == 6'h15 && be[3] && d[28]) || (w == 6'h1C && be[1] && d[11]));
    for (int c = 0; c < 2; c++) begin
      if (l[c] && !lvl[c]) np[c] = 1'b1;
      else if (!l[c] && lvl[c]) np[c] = 1'b0;
      else np[c] = m_p[c] & ~clr[c];
    end
    lvl = l; cfg_wr = wr; cfg_word = w; cfg_be = be; cfg_wdata = d;
    blk_wr = bw; blk_wdata = bd;
    @(posedge clk);
    #1;
    m_p = np;
    if (bw) m_b = bd;
    cfg_wr = 1'b0;
    blk_wr = 1'b0;
  endtask

  task automatic idle(input logic [1:0] l);
    cyc(l, 1'b0, 6'h0, 4'h0, 32'h0, 1'b0, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; lvl = 2'b00; strap = 1'b1; blk_wr = 1'b0; blk_wdata = 2'b00;
    cfg_word = 6'h0; cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0;
    m_p = 2'b00; m_b = 2'b00;
    #10 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    chk("R1 after reset");
    rd("R11 prog-if byte", 6'h02);
    rd("R11 int-pin byte", 6'h0F);
    rd("R10 ctrl strap=1", 6'h14);
    strap = 1'b0;
    rd("R10 ctrl strap=0", 6'h14);
    strap = 1'b1;

    // R2: rises
    idle(2'b01); chk("R2 ch0 rise");
    idle(2'b11); chk("R2 ch1 rise");

    // R4: legacy clears
    cyc(2'b11, 1'b1, 6'h14, 4'b0001, 32'h0, 1'b0, 2'b00); chk("R4 zero data keeps");
    cyc(2'b11, 1'b1, 6'h14, 4'b0001, 32'h4, 1'b0, 2'b00); chk("R4 ch0 legacy clear");
    idle(2'b11); idle(2'b11); chk("R12 held level no re-set");
    cyc(2'b11, 1'b1, 6'h15, 4'b1000, 32'h1000_0000, 1'b0, 2'b00); chk("R4 ch1 legacy clear");

    // R5: mode byte clears
    idle(2'b00); idle(2'b11); chk("R2 re-raise");
    cyc(2'b11, 1'b1, 6'h1C, 4'b0010, 32'h0000_0400, 1'b0, 2'b00); chk("R5 ch0 mode clear");
    cyc(2'b11, 1'b1, 6'h1C, 4'b0010, 32'h0000_0800, 1'b0, 2'b00); chk("R5 ch1 mode clear");

    // R6: other bits and disabled lanes
    idle(2'b00); idle(2'b11);
    cyc(2'b11, 1'b0, 6'h0, 4'h0, 32'h0, 1'b1, 2'b10); chk("R8 block load");
    cyc(2'b11, 1'b1, 6'h1C, 4'b1101, 32'hFFFF_FFFF, 1'b0, 2'b00); chk("R6 lane off mode");
    cyc(2'b11, 1'b1, 6'h14, 4'b1110, 32'hFFFF_FFFF, 1'b0, 2'b00); chk("R6 lane off legacy");
    cyc(2'b11, 1'b1, 6'h1C, 4'b0010, 32'h0000_3000, 1'b0, 2'b00); chk("R6 block bits read-only");

    // R7 / R8
    cyc(2'b11, 1'b0, 6'h0, 4'h0, 32'h0, 1'b1, 2'b11); chk("R7 both blocked");
    cyc(2'b11, 1'b0, 6'h0, 4'h0, 32'h0, 1'b1, 2'b00); chk("R7 none blocked");
    cyc(2'b11, 1'b0, 6'h0, 4'h0, 32'h0, 1'b1, 2'b01); chk("R7 ch0 blocked");

    // R9: rise meets clear
    idle(2'b01); chk("R3 ch1 fall");
    cyc(2'b11, 1'b1, 6'h1C, 4'b0010, 32'h0000_0800, 1'b0, 2'b00); chk("R9 rise vs mode clear");
    idle(2'b10); chk("R3 ch0 fall");
    cyc(2'b11, 1'b1, 6'h14, 4'b0001, 32'h0000_0004, 1'b0, 2'b00); chk("R9 rise vs legacy clear");
    idle(2'b00); chk("R3 both fall");

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [1:0] l;
      logic [5:0] w;
      l = lvl ^ {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)};
      case ($urandom_range(0, 3))
        0: w = 6'h14;
        1: w = 6'h15;
        2: w = 6'h1C;
        default: w = 6'($urandom_range(0, 63));
      endcase
      cyc(l, ($urandom_range(0, 1) == 1), w, 4'($urandom_range(0, 15)), $urandom(),
          ($urandom_range(0, 9) == 0), 2'($urandom_range(0, 3)));
      chk("R2 R3 R4 R5 R6 R7 R9 random");
    end

    // R1: asynchronous reset with state present
    idle(2'b00); idle(2'b11);
    cyc(2'b11, 1'b0, 6'h0, 4'h0, 32'h0, 1'b1, 2'b10);
    lvl = 2'b00;
    rst_n = 1'b0;
    #0.5;
    m_p = 2'b00; m_b = 2'b00;
    chk("R1 during reset");
    #3 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 after second reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule